// File: doc/BRIEF.md
# Setup-Frame Perfect Address Filter

This block decides, for every received frame, whether its 48-bit destination address is wanted. It keeps a table of sixteen station addresses and accepts a frame whose destination matches any of them exactly. Software loads the table by queueing a special setup frame on the transmit path. The transmit descriptor marks the buffer as setup data, and its bytes are streamed into this block instead of going to the wire.

A setup frame is always 192 bytes: sixteen 12-byte entries. Each entry holds three 32-bit little-endian words, and only the two low bytes of each word carry address data. Bytes collect in a shadow copy, and the whole table takes effect at once on the final byte. A frame cut short and restarted never reaches the table. A promiscuous input accepts every frame whatever the table holds. A separate output flags frames that were accepted only because of that override. The usual load places all-ones in entry 0 for broadcast and repeats the station address in the other entries. Repeated entries do no harm.

Top module: `setup_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, `decision_valid_o`, `accept_o` and `by_promisc_o` are 0 until a destination address is presented.
- R2: A destination presented with `dst_valid_i` high in one cycle produces `decision_valid_o` high in the next cycle with its decision, and `decision_valid_o` is 0 in cycles that follow no request. `accept_o` is 0 whenever `decision_valid_o` is 0.
- R3: From reset until the first complete setup frame has been taken, every request with `promisc_i` low is rejected, including a destination of all zeros.
- R4: Setup byte n (n = 0..191) belongs to entry n / 12 at offset o = n mod 12. Offsets 0,1,4,5,8,9 carry address bytes 0,1,2,3,4,5 in that order, and the other six offsets are ignored. Address byte k is `dst_addr_i[8k+7:8k]`.
- R5: With the table loaded, a request whose destination equals any of the 16 entries is accepted. This includes entry 0 set to all ones for broadcast and the last entry.
- R6: With the table loaded and `promisc_i` low, a destination that equals no entry is rejected.
- R7: A request with `promisc_i` high is accepted. `by_promisc_o` is 1 exactly when the request is accepted and its destination matches no active entry.
- R8: Setup-stream bytes presented with `setup_flag_i` low are ignored and leave the table unchanged.
- R9: The table changes only on the edge that takes byte 191 of a setup frame. A frame that is restarted by a new `setup_first_i` before its last byte leaves the table as it was, and the restarted frame loads in full.
- R10: A request presented in the same cycle as byte 191 is judged against the table in force before that frame. A request in the next cycle sees the new table.
- R11: Flagged bytes that arrive while no setup frame is open (no `setup_first_i` since the last completed frame) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_valid_i | input | 1 | A transmit-path byte is present this cycle |
| setup_flag_i | input | 1 | Descriptor marks the current buffer as setup data |
| setup_first_i | input | 1 | This byte is byte 0 of a setup frame |
| setup_data_i | input | 8 | Transmit-path byte |
| dst_valid_i | input | 1 | Destination address lookup request |
| dst_addr_i | input | 48 | Destination address, byte 0 in bits 7:0 |
| promisc_i | input | 1 | Accept every frame |
| decision_valid_o | output | 1 | Decision for last cycle's request is present |
| accept_o | output | 1 | Frame accepted |
| by_promisc_o | output | 1 | Accepted only by the promiscuous override |

## Verification
The two functions that can meet in one cycle are the table commit on byte 191 and a destination lookup. The bench holds back the final byte of a setup frame. It then drives that byte in the same cycle as a lookup of an address that only the new table contains. A reject is expected for that lookup, and an accept is expected for the same address one cycle later. Partial, unflagged and orphaned setup streams are each followed by lookups that show which table is in force.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  localparam int unsigned ADDR_BYTES  = 6;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned LANES_USED  = 2;
  localparam int unsigned ENTRY_WORDS = ADDR_BYTES / LANES_USED;
  localparam int unsigned ENTRY_BYTES = ENTRY_WORDS * WORD_BYTES;
  localparam int unsigned ADDR_W      = ADDR_BYTES * 8;

  typedef logic [ADDR_W-1:0] mac_t;
endpackage

// File: rtl/setup_loader.sv
module setup_loader
  import afilt_pkg::*;
#(
  parameter int unsigned N_ENTRY = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    setup_valid_i,
  input  logic                    setup_flag_i,
  input  logic                    setup_first_i,
  input  logic [7:0]              setup_data_i,
  output logic [N_ENTRY-1:0][ADDR_W-1:0] shadow_o,
  output logic                    commit_o
);
  localparam int unsigned FRAME_LEN = N_ENTRY * ENTRY_BYTES;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
  localparam int unsigned ENT_W     = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

  logic [CNT_W-1:0] cnt_q, pos;
  logic             open_q, take, last;
  logic [N_ENTRY-1:0][ADDR_W-1:0] shadow_q, shadow_d;
  int unsigned pos_i, ent_i, off_i, word_i, lane_i, abyte_i;
  logic is_addr;

  always_comb begin
    take    = setup_valid_i && setup_flag_i && (setup_first_i || open_q);
    pos     = setup_first_i ? '0 : cnt_q;
    pos_i   = 32'(pos);
    ent_i   = pos_i / ENTRY_BYTES;
    off_i   = pos_i % ENTRY_BYTES;
    word_i  = off_i / WORD_BYTES;
    lane_i  = off_i % WORD_BYTES;
    abyte_i = word_i * LANES_USED + lane_i;
    is_addr = (lane_i < LANES_USED) && (word_i < ENTRY_WORDS);
    last    = (pos == CNT_W'(FRAME_LEN - 1));
    shadow_d = shadow_q;
    if (take && is_addr)
      shadow_d[ent_i[ENT_W-1:0]][abyte_i*8 +: 8] = setup_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      open_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (take) begin
        if (last) begin
          cnt_q  <= '0;
          open_q <= 1'b0;
        end else begin
          cnt_q  <= pos + CNT_W'(1);
          open_q <= 1'b1;
        end
      end
    end
  end

  assign shadow_o = shadow_d;
  assign commit_o = take && last;
endmodule

// File: rtl/addr_table.sv
module addr_table
  import afilt_pkg::*;
#(
  parameter int unsigned N_ENTRY = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [N_ENTRY-1:0][ADDR_W-1:0] shadow_i,
  input  logic [ADDR_W-1:0]       dst_i,
  output logic                    loaded_o,
  output logic [N_ENTRY-1:0]      hit_o
);
  logic loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       loaded_q <= 1'b0;
    else if (commit_i) loaded_q <= 1'b1;
  end

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_ent
    mac_t tab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       tab_q <= '0;
      else if (commit_i) tab_q <= shadow_i[e];
    end
    assign hit_o[e] = loaded_q && (tab_q == dst_i);
  end

  assign loaded_o = loaded_q;
endmodule

// File: rtl/filt_decide.sv
module filt_decide #(
  parameter int unsigned N_ENTRY = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dst_valid_i,
  input  logic               promisc_i,
  input  logic [N_ENTRY-1:0] hit_i,
  output logic               valid_o,
  output logic               accept_o,
  output logic               by_promisc_o
);
  logic any_hit;
  assign any_hit = |hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      accept_o     <= 1'b0;
      by_promisc_o <= 1'b0;
    end else begin
      valid_o      <= dst_valid_i;
      accept_o     <= dst_valid_i && (any_hit || promisc_i);
      by_promisc_o <= dst_valid_i && promisc_i && !any_hit;
    end
  end
endmodule

// File: rtl/setup_addr_filter.sv
module setup_addr_filter
  import afilt_pkg::*;
#(
  parameter int unsigned N_ENTRY = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        setup_valid_i,
  input  logic        setup_flag_i,
  input  logic        setup_first_i,
  input  logic [7:0]  setup_data_i,
  input  logic        dst_valid_i,
  input  logic [47:0] dst_addr_i,
  input  logic        promisc_i,
  output logic        decision_valid_o,
  output logic        accept_o,
  output logic        by_promisc_o
);
  logic [N_ENTRY-1:0][ADDR_W-1:0] shadow;
  logic                 commit;
  logic                 tbl_loaded;
  logic [N_ENTRY-1:0]   hit;

  setup_loader #(.N_ENTRY(N_ENTRY)) u_loader (
    .clk_i, .rst_ni,
    .setup_valid_i, .setup_flag_i, .setup_first_i, .setup_data_i,
    .shadow_o (shadow),
    .commit_o (commit)
  );

  addr_table #(.N_ENTRY(N_ENTRY)) u_table (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .shadow_i (shadow),
    .dst_i    (dst_addr_i),
    .loaded_o (tbl_loaded),
    .hit_o    (hit)
  );

  filt_decide #(.N_ENTRY(N_ENTRY)) u_decide (
    .clk_i, .rst_ni,
    .dst_valid_i, .promisc_i,
    .hit_i        (hit),
    .valid_o      (decision_valid_o),
    .accept_o     (accept_o),
    .by_promisc_o (by_promisc_o)
  );
endmodule

// File: rtl/setup_addr_filter_chk.sv
module setup_addr_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic setup_valid_i,
  input logic setup_flag_i,
  input logic dst_valid_i,
  input logic promisc_i,
  input logic decision_valid_o,
  input logic accept_o,
  input logic by_promisc_o,
  input logic commit,
  input logic tbl_loaded
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_i |=> decision_valid_o);                                   // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dst_valid_i |=> !decision_valid_o);                                 // R2
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> !accept_o);                                    // R2
  AST_UNLOADED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && !promisc_i && !tbl_loaded) |=> !accept_o);           // R3
  AST_PROMISC_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_valid_i && promisc_i) |=> accept_o);                            // R7
  AST_OVERRIDE_IMPLIES_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    by_promisc_o |-> accept_o);                                          // R7
  AST_COMMIT_ON_FLAGGED_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (setup_valid_i && setup_flag_i));                         // R8
  AST_LOADED_ONLY_BY_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tbl_loaded) |-> $past(commit));                                // R9
endmodule

bind setup_addr_filter setup_addr_filter_chk u_chk (
  .clk_i, .rst_ni, .setup_valid_i, .setup_flag_i, .dst_valid_i, .promisc_i,
  .decision_valid_o, .accept_o, .by_promisc_o,
  .commit (commit), .tbl_loaded (tbl_loaded)
);

// File: tb/tb_setup_addr_filter.sv
module tb_setup_addr_filter;
  localparam int CLK_P = 10;
  localparam int NE    = 16;
  localparam int FLEN  = NE * 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic setup_valid = 0, setup_flag = 0, setup_first = 0;
  logic [7:0] setup_data = '0;
  logic dst_valid = 0, promisc = 0;
  logic [47:0] dst_addr = '0;
  logic decision_valid, accept, by_promisc;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [47:0] tb_tab [NE];

  always #(CLK_P/2) clk = ~clk;

  setup_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .setup_valid_i(setup_valid), .setup_flag_i(setup_flag),
    .setup_first_i(setup_first), .setup_data_i(setup_data),
    .dst_valid_i(dst_valid), .dst_addr_i(dst_addr), .promisc_i(promisc),
    .decision_valid_o(decision_valid), .accept_o(accept), .by_promisc_o(by_promisc)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int n);
    int e = n / 12;
    int o = n % 12;
    int w = o / 4;
    int l = o % 4;
    if (l < 2) return tb_tab[e][8*(2*w+l) +: 8];
    return 8'(n * 7 + 3);
  endfunction

  task automatic send_frame(input logic flag, input logic use_first, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      setup_valid = 1; setup_flag = flag;
      setup_first = use_first && (i == 0);
      setup_data  = frame_byte(i);
    end
    @(negedge clk);
    setup_valid = 0; setup_flag = 0; setup_first = 0;
  endtask

  task automatic lookup(input logic [47:0] a, input logic pm, input logic exp_acc,
                        input logic exp_bp, input string req);
    @(negedge clk);
    dst_valid = 1; dst_addr = a; promisc = pm;
    @(negedge clk);
    dst_valid = 0; promisc = 0;
    chk({req, " valid"}, 48'(decision_valid), 48'd1);
    chk({req, " accept"}, 48'(accept), 48'(exp_acc));
    chk({req, " by_promisc"}, 48'(by_promisc), 48'(exp_bp));
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", 48'(decision_valid), 48'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 valid", 48'(decision_valid), 48'd0);
    chk("R1 accept", 48'(accept), 48'd0);
    chk("R1 by_promisc", 48'(by_promisc), 48'd0);
  endtask

  task automatic t_unloaded();
    lookup(48'h0, 0, 0, 0, "R3 zero addr unloaded");
    lookup(48'hFFFF_FFFF_FFFF, 0, 0, 0, "R3 broadcast unloaded");
    lookup(48'h1234_5678_9ABC, 1, 1, 1, "R7 promisc unloaded");
    @(negedge clk);
    chk("R2 idle valid", 48'(decision_valid), 48'd0);
    chk("R2 idle accept", 48'(accept), 48'd0);
  endtask

  task automatic t_load_a();
    tb_tab[0] = 48'hFFFF_FFFF_FFFF;
    for (int e = 1; e < NE; e++) tb_tab[e] = 48'h0605_0403_0201;
    send_frame(1, 1, FLEN);
    lookup(48'hFFFF_FFFF_FFFF, 0, 1, 0, "R5 broadcast entry");
    lookup(48'h0605_0403_0201, 0, 1, 0, "R5 station entry");
    lookup(48'h0605_0403_0202, 0, 0, 0, "R6 near miss");
    lookup(48'h0605_0403_0202, 1, 1, 1, "R7 promisc miss");
    lookup(48'h0605_0403_0201, 1, 1, 0, "R7 promisc hit");
  endtask

  task automatic t_map();
    for (int e = 0; e < NE; e++)
      tb_tab[e] = {8'(8'h50 + e), 8'h44, 8'h33, 8'h22, 8'h11, 8'(e)};
    send_frame(1, 1, FLEN);
    lookup({8'h57, 8'h44, 8'h33, 8'h22, 8'h11, 8'h07}, 0, 1, 0, "R4 entry 7 mapping");
    lookup({8'h22, 8'h11, 8'h07, 8'h57, 8'h44, 8'h33}, 0, 0, 0, "R4 swapped halves");
    lookup({8'h5F, 8'h44, 8'h33, 8'h22, 8'h11, 8'h0F}, 0, 1, 0, "R5 last entry");
    lookup(48'h0605_0403_0201, 0, 0, 0, "R9 old table replaced");
  endtask

  task automatic t_unflagged();
    for (int e = 0; e < NE; e++) tb_tab[e] = 48'hAAAA_0000_0000 + 48'(e);
    send_frame(0, 1, FLEN);
    lookup(48'hAAAA_0000_0003, 0, 0, 0, "R8 unflagged not loaded");
    lookup({8'h57, 8'h44, 8'h33, 8'h22, 8'h11, 8'h07}, 0, 1, 0, "R8 table kept");
  endtask

  task automatic t_partial();
    for (int e = 0; e < NE; e++) tb_tab[e] = 48'hBBBB_0000_0000 + 48'(e);
    send_frame(1, 1, 100);
    lookup(48'hBBBB_0000_0002, 0, 0, 0, "R9 partial not applied");
    lookup({8'h57, 8'h44, 8'h33, 8'h22, 8'h11, 8'h07}, 0, 1, 0, "R9 old table in force");
    for (int e = 0; e < NE; e++) tb_tab[e] = 48'hCCCC_0000_0000 + 48'(e);
    send_frame(1, 1, FLEN);
    lookup(48'hCCCC_0000_000C, 0, 1, 0, "R9 restarted frame loaded");
    lookup(48'hBBBB_0000_0002, 0, 0, 0, "R9 abandoned data absent");
  endtask

  task automatic t_orphan();
    for (int e = 0; e < NE; e++) tb_tab[e] = 48'hDDDD_0000_0000 + 48'(e);
    send_frame(1, 0, FLEN);
    lookup(48'hDDDD_0000_0001, 0, 0, 0, "R11 orphan bytes ignored");
    lookup(48'hCCCC_0000_0001, 0, 1, 0, "R11 table kept");
  endtask

  task automatic t_collide();
    for (int e = 0; e < NE; e++) tb_tab[e] = 48'hEEEE_0000_0000 + 48'(e);
    send_frame(1, 1, FLEN - 1);
    @(negedge clk);
    setup_valid = 1; setup_flag = 1; setup_first = 0; setup_data = frame_byte(FLEN - 1);
    dst_valid = 1; dst_addr = 48'hEEEE_0000_0005; promisc = 0;
    @(negedge clk);
    setup_valid = 0; setup_flag = 0;
    chk("R10 same-cycle valid", 48'(decision_valid), 48'd1);
    chk("R10 same-cycle old table", 48'(accept), 48'd0);
    @(negedge clk);
    dst_valid = 0;
    chk("R10 next-cycle new table", 48'(accept), 48'd1);
    lookup(48'hCCCC_0000_0005, 0, 0, 0, "R10 prior table gone");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_unloaded();
    t_load_a();
    t_map();
    t_unflagged();
    t_partial();
    t_orphan();
    t_collide();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule